// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the command sequence for a DMA transfer that moves a block of quadwords (16-byte units) between a linear local memory and a main memory laid out with gaps. Software or a parent controller gives it a total quadword count, a chunk size, a skip size and a start address for each side, then pulses `start`. The block splits the total into chunks. For each chunk it issues one command carrying a main-memory byte address, a local-memory byte address and a length in quadwords.

The local side stays contiguous from one chunk to the next. The main side moves forward by the chunk and then jumps over `skip_qw` further quadwords before the next chunk. A chunk size of zero means the whole total goes out as one command. The same sequence serves both directions. A direction bit is latched at start and carried on every command so the data mover knows which side is the source. When the last chunk has been accepted, `done` rises and stays high until the next start.

Top module: `strided_dma_agen`

## Requirements
- R1: Each command length equals the smaller of the effective chunk size and the quadwords still to move, so only the final chunk can be shorter.
- R2: A chunk size of zero makes the effective chunk size equal to the total, so the transfer is one command of `total_qw` quadwords.
- R3: The first command carries `local_base` and `main_base` as latched at start.
- R4: Between consecutive commands of a transfer, the local address grows by length*16 bytes.
- R5: Between consecutive commands of a transfer, the main address grows by (skip + length)*16 bytes.
- R6: After the last chunk is accepted, `cmd_valid` is low, `busy` is low and `done` is high from the next cycle, and `done` holds until the next accepted start, which clears it.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the command fields hold stable and `cmd_valid` stays high.
- R8: A start with a total of zero sets `done` in the following cycle and issues no command.
- R9: A start pulse or changed inputs while a transfer is running have no effect on that transfer.
- R10: `cmd_dir` on every command equals the `dir` value latched at start. The addresses do not depend on it.
- R11: After reset, `cmd_valid`, `busy` and `done` are low.
- R12: With `cmd_ready` held high, one command is accepted per cycle, so a transfer of N chunks shows `cmd_valid` for exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; sampled only while idle |
| dir | input | 1 | Direction: 0 local-to-main, 1 main-to-local |
| total_qw | input | 16 | Quadwords to move in total |
| chunk_qw | input | 16 | Quadwords per chunk; 0 selects the whole total |
| skip_qw | input | 16 | Quadwords skipped in main memory after each chunk |
| main_base | input | 32 | Main-memory start byte address |
| local_base | input | 32 | Local-memory start byte address |
| cmd_valid | output | 1 | A chunk command is presented |
| cmd_ready | input | 1 | The data mover accepts the command this cycle |
| cmd_main_addr | output | 32 | Main-memory byte address of the chunk |
| cmd_local_addr | output | 32 | Local-memory byte address of the chunk |
| cmd_len | output | 16 | Chunk length in quadwords |
| cmd_dir | output | 1 | Latched direction for this transfer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | The last transfer has completed |

## Verification
The bench targets the following corner cases:
- A total that is not a multiple of the chunk, where a design without the min rule would issue a full-size final chunk and overrun the count.
- A zero chunk size and a chunk larger than the total. Mishandling either would issue zero-length commands or hang.
- A zero total. A wrong design would issue a zero-length command or never raise `done`.
- A skip of zero and the largest skip value, where adding the skip to the wrong side, or at the wrong width, gives wrong main addresses.
- Irregular `cmd_ready` patterns. A design that advances without a handshake would skip or repeat chunks.
- A start pulse during a running transfer, which a careless design would take as a restart.

// File: rtl/sdma_agen_pkg.sv
// Package: shared constants and types for the strided DMA address generator.
// Assumes quadword units of 16 bytes.
package sdma_agen_pkg;
    localparam int QW_SHIFT = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } agen_state_e;
endpackage

// File: rtl/sdma_chunk_sizer.sv
// Module: sdma_chunk_sizer
// Computes the length of the next chunk as the smaller of the effective
// chunk size and the remaining count. Purely combinational.
// Assumes chunk_eff is nonzero whenever remaining is nonzero.
module sdma_chunk_sizer #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] remaining,
    input  logic [CNT_W-1:0] chunk_eff,
    output logic [CNT_W-1:0] len
);
    // pick min(chunk, remaining)
    always_comb begin
        if (remaining < chunk_eff) len = remaining;
        else                       len = chunk_eff;
    end
endmodule

// File: rtl/sdma_addr_step.sv
// Module: sdma_addr_step
// One address pointer. Loads a base and a gap on load. On each step it
// advances by (gap + len) quadwords, expressed in bytes.
// Assumes ADDR_W is wide enough that (gap+len)<<QW_SHIFT does not truncate.
module sdma_addr_step
    import sdma_agen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  gap,
    input  logic              step,
    input  logic [CNT_W-1:0]  len,
    output logic [ADDR_W-1:0] addr
);
    logic [CNT_W-1:0]  gap_q;
    logic [ADDR_W-1:0] stride_bytes;

    // byte distance to the next chunk
    always_comb begin
        stride_bytes = (ADDR_W'(gap_q) + ADDR_W'(len)) << QW_SHIFT;
    end

    // pointer and gap registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            gap_q <= '0;
        end else if (load) begin
            addr  <= base;
            gap_q <= gap;
        end else if (step) begin
            addr  <= addr + stride_bytes;
        end
    end
endmodule

// File: rtl/sdma_agen_ctrl.sv
// Module: sdma_agen_ctrl
// Sequencer. It accepts a start only while idle and latches the count, the
// effective chunk size and the direction. It counts down the remaining
// quadwords on each accepted command and raises a sticky done.
// Assumes len from the sizer is nonzero whenever the remaining count is nonzero.
module sdma_agen_ctrl
    import sdma_agen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] chunk,
    input  logic             ready,
    input  logic [CNT_W-1:0] len,
    output logic             valid,
    output logic             load,
    output logic             fire,
    output logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] chunk_eff,
    output logic             dir_q,
    output logic             busy,
    output logic             done
);
    agen_state_e state;
    logic        last_chunk;

    // handshake and control decode
    always_comb begin
        valid      = (state == ST_RUN);
        busy       = (state == ST_RUN);
        load       = start && (state == ST_IDLE);
        fire       = valid && ready;
        last_chunk = (remaining == len);
    end

    // state, counters and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            chunk_eff <= '0;
            dir_q     <= 1'b0;
            done      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        dir_q     <= dir;
                        remaining <= total;
                        chunk_eff <= (chunk == '0) ? total : chunk;
                        if (total == '0) begin
                            done  <= 1'b1;
                        end else begin
                            done  <= 1'b0;
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (fire) begin
                        remaining <= remaining - len;
                        if (last_chunk) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    // R8
    zero_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && total == '0) |=> (done && !valid));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start && !ready) |=> (valid && $stable(remaining) && $stable(dir_q)));
endmodule

// File: rtl/strided_dma_agen.sv
// Module: strided_dma_agen (top)
// Strided interleave DMA address generator. It issues one command per chunk
// with main address, local address and length. The local side is contiguous
// and the main side skips skip_qw quadwords after each chunk.
// Assumes the data mover takes a command on any cycle with valid and ready high.
module strided_dma_agen
    import sdma_agen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [CNT_W-1:0]  total_qw,
    input  logic [CNT_W-1:0]  chunk_qw,
    input  logic [CNT_W-1:0]  skip_qw,
    input  logic [ADDR_W-1:0] main_base,
    input  logic [ADDR_W-1:0] local_base,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_main_addr,
    output logic [ADDR_W-1:0] cmd_local_addr,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              cmd_dir,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] NO_GAP = '0;

    logic             load;
    logic             fire;
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] chunk_eff;

    sdma_agen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir       (dir),
        .total     (total_qw),
        .chunk     (chunk_qw),
        .ready     (cmd_ready),
        .len       (cmd_len),
        .valid     (cmd_valid),
        .load      (load),
        .fire      (fire),
        .remaining (remaining),
        .chunk_eff (chunk_eff),
        .dir_q     (cmd_dir),
        .busy      (busy),
        .done      (done)
    );

    sdma_chunk_sizer #(.CNT_W(CNT_W)) u_sizer (
        .remaining (remaining),
        .chunk_eff (chunk_eff),
        .len       (cmd_len)
    );

    sdma_addr_step #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_main_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .base  (main_base),
        .gap   (skip_qw),
        .step  (fire),
        .len   (cmd_len),
        .addr  (cmd_main_addr)
    );

    sdma_addr_step #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_local_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .base  (local_base),
        .gap   (NO_GAP),
        .step  (fire),
        .len   (cmd_len),
        .addr  (cmd_local_addr)
    );

    // R1
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0 && cmd_len <= remaining));

    // R7
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_len)
            && $stable(cmd_main_addr) && $stable(cmd_local_addr)));

    // R4
    local_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !$past(load)) |=> (cmd_local_addr - $past(cmd_local_addr)
            == (ADDR_W'($past(cmd_len)) << QW_SHIFT)));

    // R3
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cmd_main_addr == $past(main_base) && cmd_local_addr == $past(local_base)));
endmodule

// File: tb/strided_dma_agen_test.sv
module strided_dma_agen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [15:0] total_qw = '0, chunk_qw = '0, skip_qw = '0;
    logic [31:0] main_base = '0, local_base = '0;
    logic        cmd_valid, cmd_ready = 1'b0, cmd_dir, busy, done;
    logic [31:0] cmd_main_addr, cmd_local_addr;
    logic [15:0] cmd_len;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    strided_dma_agen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .total_qw(total_qw), .chunk_qw(chunk_qw), .skip_qw(skip_qw),
        .main_base(main_base), .local_base(local_base),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_main_addr(cmd_main_addr), .cmd_local_addr(cmd_local_addr),
        .cmd_len(cmd_len), .cmd_dir(cmd_dir), .busy(busy), .done(done)
    );

    // {total, chunk, skip, main_base, local_base, dir}
    localparam int NV = 6;
    localparam logic [112:0] VECS [0:NV-1] = '{
        {16'd10, 16'd3,  16'd2,      32'h0000_1000, 32'h0000_0200, 1'b0},
        {16'd8,  16'd0,  16'd5,      32'h0000_2000, 32'h0000_0040, 1'b1},
        {16'd5,  16'd8,  16'd1,      32'h0000_3000, 32'h0000_0000, 1'b0},
        {16'd12, 16'd4,  16'd0,      32'h0001_0000, 32'h0000_0100, 1'b1},
        {16'd7,  16'd1,  16'd3,      32'h0000_4000, 32'h0000_0800, 1'b1},
        {16'd16, 16'd16, 16'hFFFF,   32'h0010_0000, 32'h0000_0010, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // run one transfer; mode 0: ready always high, 1: irregular ready
    // poke: pulse start with other inputs in the middle (R9)
    task automatic run_xfer(input logic [112:0] v, input int mode, input bit poke);
        int rem, ce, skp, n_valid, n_chunks, k;
        logic [31:0] m, l;
        logic [31:0] pm, pl;
        logic [15:0] plen;
        bit pv, pr, d;
        {total_qw, chunk_qw, skip_qw, main_base, local_base, dir} = v;
        rem = int'(total_qw);
        ce = (chunk_qw == 0) ? rem : int'(chunk_qw);
        skp = int'(skip_qw);
        m = main_base; l = local_base; d = dir;
        n_chunks = (rem + ce - 1) / ce;
        n_valid = 0; pv = 0; pr = 0; pm = 0; pl = 0; plen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R6: accepted start clears done
        check(done == 1'b0, "R6", "done cleared on start", done, 0);
        k = 0;
        while (1) begin
            int exp_len;
            bit rdy;
            if (k > 500) begin
                check(0, "R6", "transfer never finished", 0, 1);
                break;
            end
            if (pv && !pr) begin
                // R7
                check(cmd_valid && cmd_len == plen && cmd_main_addr == pm && cmd_local_addr == pl,
                      "R7", "hold while stalled", cmd_main_addr, pm);
            end
            if (!cmd_valid) begin
                // R6
                check(rem == 0, "R6", "remaining when valid dropped", rem, 0);
                check(done && !busy, "R6", "done/busy after last", {done, busy}, 2'b10);
                break;
            end
            n_valid++;
            exp_len = (rem < ce) ? rem : ce;
            check(int'(cmd_len) == exp_len, (chunk_qw == 0) ? "R2" : "R1", "len", cmd_len, exp_len);
            check(cmd_main_addr == m, (k == 0) ? "R3" : "R5", "main addr", cmd_main_addr, m);
            check(cmd_local_addr == l, (k == 0) ? "R3" : "R4", "local addr", cmd_local_addr, l);
            check(cmd_dir == d, "R10", "dir", cmd_dir, d);
            check(busy, "R6", "busy during run", busy, 1);
            rdy = (mode == 0) ? 1'b1 : ((k % 3) != 1);
            pv = cmd_valid; pr = rdy; pm = cmd_main_addr; pl = cmd_local_addr; plen = cmd_len;
            cmd_ready = rdy;
            if (rdy) begin
                rem -= exp_len;
                m += 32'((skp + exp_len) << 4);
                l += 32'(exp_len << 4);
            end
            if (poke && k == 1) begin
                start = 1'b1; total_qw = 16'd3; chunk_qw = 16'd1; skip_qw = 16'd9;
                main_base = 32'hDEAD_0000; local_base = 32'h0BAD_0000; dir = ~dir;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        cmd_ready = 1'b0;
        if (mode == 0)
            // R12
            check(n_valid == n_chunks, "R12", "valid cycles", n_valid, n_chunks);
        repeat (3) @(negedge clk);
        // R6: done sticky
        check(done && !cmd_valid, "R6", "done held", {done, cmd_valid}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11
        check(!cmd_valid && !busy && !done, "R11", "reset outputs", {cmd_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && !busy && !done, "R11", "idle after reset", {cmd_valid, busy, done}, 0);

        for (int i = 0; i < NV; i++) run_xfer(VECS[i], 0, 0);
        for (int i = 0; i < NV; i++) run_xfer(VECS[i], 1, 0);

        // R9: start during a running transfer ignored
        run_xfer(VECS[0], 1, 1);

        // R8: zero total
        total_qw = 16'd0; chunk_qw = 16'd4; skip_qw = 16'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !cmd_valid && !busy, "R8", "zero total done", {done, cmd_valid, busy}, 3'b100);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(!cmd_valid, "R8", "no command for zero total", cmd_valid, 0);
        end

        // R11: reset in the middle of a transfer
        {total_qw, chunk_qw, skip_qw, main_base, local_base, dir} = VECS[3];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cmd_valid, "R11", "running before reset", cmd_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!cmd_valid && !busy && !done, "R11", "mid-run reset", {cmd_valid, busy, done}, 0);
        @(negedge clk);
        check(!cmd_valid, "R11", "stays idle", cmd_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule